// File: doc/BRIEF.md
# LCD Interrupt Status Unit

This block collects the event sources of an LCD display controller into four maskable interrupt lines and one combined interrupt. Each source sets a sticky status bit. An enable register masks the status bits, and only the masked result reaches the outputs. Software acknowledges an event by writing ones to a separate clear register.

Two of the four sources are produced inside the block. The vertical-compare source watches the region code of the timing generator. It fires once, when the code enters the region that software has selected. The frame-base source holds a base address that software has written and marks it pending. At the next frame-start pulse it copies that address into the active base register and raises its event. The other two sources are single-cycle pulses from outside: DMA FIFO underflow and bus error. Registers are reached through a plain single-cycle write port and a combinational read port.

Top module: `lcd_irq_unit`

## Requirements
- R1: While reset is held and right after it, the status, enable, compare-select and active-base registers read zero, and `irq_vec_o` and `irq_o` are low.
- R2: The status register (word address 3) holds sources at fixed bits: bit 0 FIFO underflow, bit 1 frame base taken, bit 2 vertical compare, bit 3 bus error. A bit sets on the clock edge that samples its event, and it stays set whatever the enable mask holds.
- R3: The enable register (word address 1, bits 3:0, same bit order) gates the outputs: `irq_vec_o` equals status AND enable, and `irq_o` is high exactly when `irq_vec_o` is nonzero.
- R4: A write to the clear register (word address 2) clears every status bit written as one and leaves the others. The clear register always reads zero.
- R5: If an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: The compare-select register (word address 0, bits 1:0) picks a region code: 0 vertical sync, 1 back porch, 2 active image, 3 front porch. `vregion_i` uses the same codes. Status bit 2 sets on the cycle in which `vregion_i` first equals the selected code after holding a different one.
- R7: While `vregion_i` stays in the selected region, no further compare events occur. A clear issued inside the region leaves bit 2 at zero.
- R8: A write to word address 4 stores the next base and marks it pending. A `frame_start_i` pulse with a base pending copies it to `base_active_o` (also readable at word address 5), clears the pending mark and sets status bit 1. A frame start with nothing pending changes nothing.
- R9: Writes to the status register (address 3) and to the active-base register (address 5) have no effect.
- R10: When a next-base write and a frame start fall in the same cycle, the frame start commits the base that was already pending, if any. The newly written base stays pending for the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ufl_pulse_i | input | 1 | FIFO underflow event, one cycle |
| berr_pulse_i | input | 1 | Bus error event, one cycle |
| frame_start_i | input | 1 | Start-of-frame pulse from the timing generator |
| vregion_i | input | 2 | Current vertical region code |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data for `reg_addr_i`, combinational |
| base_active_o | output | BASE_W | Base address in use for the current frame |
| irq_vec_o | output | 4 | Masked individual interrupts |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every status bit, the active base and the register contents change on the clock edge that samples the event pulse, the frame-start pulse or the write strobe. They are therefore due one cycle after a stimulus is driven. The outputs `irq_vec_o`, `irq_o` and `reg_rdata_o` are combinational from registers and the read address. The bench drives each stimulus on a falling edge and holds it across one rising edge. It reads results just after the next falling edge, when exactly one register stage has passed. The mask sweep runs all 16 status patterns against all 16 enable masks. The compare sweep steps through every region code for each select value.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  localparam int NSRC = 4;
  localparam int SRC_UFL  = 0;
  localparam int SRC_FBT  = 1;
  localparam int SRC_VCMP = 2;
  localparam int SRC_BERR = 3;

  typedef enum logic [1:0] {
    VR_SYNC   = 2'd0,
    VR_BPORCH = 2'd1,
    VR_ACTIVE = 2'd2,
    VR_FPORCH = 2'd3
  } vregion_e;

  localparam int A_VSEL  = 0;
  localparam int A_IEN   = 1;
  localparam int A_ICLR  = 2;
  localparam int A_ISTAT = 3;
  localparam int A_BNEXT = 4;
  localparam int A_BACT  = 5;
endpackage

// File: rtl/lcd_irq_vcmp.sv
module lcd_irq_vcmp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] vregion_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  logic [1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= lcd_irq_pkg::VR_SYNC;
    else        prev_q <= vregion_i;
  end

  // fire only on entry into the selected region
  assign hit_o = (vregion_i == sel_i) && (prev_q != vregion_i);
endmodule

// File: rtl/lcd_irq_fbase.sv
module lcd_irq_fbase #(
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BASE_W-1:0] wdata_i,
  input  logic              frame_start_i,
  output logic [BASE_W-1:0] active_o,
  output logic              taken_o
);
  logic [BASE_W-1:0] next_q;
  logic              pend_q;

  assign taken_o = frame_start_i && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q   <= '0;
      pend_q   <= 1'b0;
      active_o <= '0;
    end else begin
      if (taken_o) active_o <= next_q;
      if (wr_i) begin
        next_q <= wdata_i;
        pend_q <= 1'b1;
      end else if (taken_o) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lcd_irq_stat.sv
module lcd_irq_stat #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        stat_o[b] <= 1'b0;
      else if (ev_i[b])  stat_o[b] <= 1'b1;   // event beats a clear
      else if (clr_i[b]) stat_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit #(
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ufl_pulse_i,
  input  logic              berr_pulse_i,
  input  logic              frame_start_i,
  input  logic [1:0]        vregion_i,
  input  logic              reg_wr_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [BASE_W-1:0] base_active_o,
  output logic [3:0]        irq_vec_o,
  output logic              irq_o
);
  import lcd_irq_pkg::*;

  logic [NSRC-1:0] en_q, stat_q, ev, clr;
  logic [1:0]      vsel_q;
  logic            vhit, btaken;
  logic            wr_vsel, wr_ien, wr_iclr, wr_bnext;

  assign wr_vsel  = reg_wr_i && (reg_addr_i == AW'(A_VSEL));
  assign wr_ien   = reg_wr_i && (reg_addr_i == AW'(A_IEN));
  assign wr_iclr  = reg_wr_i && (reg_addr_i == AW'(A_ICLR));
  assign wr_bnext = reg_wr_i && (reg_addr_i == AW'(A_BNEXT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      vsel_q <= VR_SYNC;
    end else begin
      if (wr_ien)  en_q   <= reg_wdata_i[NSRC-1:0];
      if (wr_vsel) vsel_q <= reg_wdata_i[1:0];
    end
  end

  lcd_irq_vcmp u_vcmp (
    .clk(clk), .rst_n(rst_n), .vregion_i(vregion_i), .sel_i(vsel_q), .hit_o(vhit)
  );

  lcd_irq_fbase #(.BASE_W(BASE_W)) u_fbase (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_bnext), .wdata_i(reg_wdata_i[BASE_W-1:0]),
    .frame_start_i(frame_start_i), .active_o(base_active_o), .taken_o(btaken)
  );

  always_comb begin
    ev           = '0;
    ev[SRC_UFL]  = ufl_pulse_i;
    ev[SRC_FBT]  = btaken;
    ev[SRC_VCMP] = vhit;
    ev[SRC_BERR] = berr_pulse_i;
  end

  assign clr = wr_iclr ? reg_wdata_i[NSRC-1:0] : '0;

  lcd_irq_stat #(.N(NSRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .clr_i(clr), .stat_o(stat_q)
  );

  assign irq_vec_o = stat_q & en_q;
  assign irq_o     = |irq_vec_o;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(A_VSEL):  reg_rdata_o[1:0]      = vsel_q;
      AW'(A_IEN):   reg_rdata_o[NSRC-1:0] = en_q;
      AW'(A_ISTAT): reg_rdata_o[NSRC-1:0] = stat_q;
      AW'(A_BACT):  reg_rdata_o = DW'(base_active_o);
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lcd_irq_chk.sv
module lcd_irq_chk #(
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int BASE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ufl_pulse_i,
  input logic              frame_start_i,
  input logic [1:0]        vregion_i,
  input logic              reg_wr_i,
  input logic [AW-1:0]     reg_addr_i,
  input logic [DW-1:0]     reg_rdata_o,
  input logic [BASE_W-1:0] base_active_o,
  input logic [3:0]        irq_vec_o,
  input logic              irq_o,
  input logic [3:0]        stat_q,
  input logic [3:0]        en_q,
  input logic [1:0]        vsel_q
);
  import lcd_irq_pkg::*;

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == AW'(A_ICLR)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_irq_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((stat_q & en_q) != 4'd0));

  p_irq_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) != 4'd0) |-> (irq_o && ((irq_vec_o & ~en_q) == 4'd0)));

  p_clr_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == AW'(A_ICLR)) |-> (reg_rdata_o == '0));

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ufl_pulse_i |=> stat_q[SRC_UFL]);

  p_vcmp_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[SRC_VCMP]) |-> ($past(vregion_i) == $past(vsel_q)));

  p_base_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_active_o) |-> ($past(frame_start_i) && stat_q[SRC_FBT]));
endmodule

bind lcd_irq_unit lcd_irq_chk #(.DW(DW), .AW(AW), .BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ufl_pulse_i(ufl_pulse_i), .frame_start_i(frame_start_i),
  .vregion_i(vregion_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .base_active_o(base_active_o), .irq_vec_o(irq_vec_o),
  .irq_o(irq_o), .stat_q(stat_q), .en_q(en_q), .vsel_q(vsel_q)
);

// File: tb/sim_lcd_irq_unit.sv
module sim_lcd_irq_unit;
  localparam int CLK_P = 10;
  localparam int DW = 32, AW = 3, BW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ufl = 1'b0, berr = 1'b0, fstart = 1'b0, wr = 1'b0;
  logic [1:0] vreg = 2'd3;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [BW-1:0] bact;
  logic [3:0] ivec;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lcd_irq_unit #(.DW(DW), .AW(AW), .BASE_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .ufl_pulse_i(ufl), .berr_pulse_i(berr),
    .frame_start_i(fstart), .vregion_i(vreg), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .base_active_o(bact),
    .irq_vec_o(ivec), .irq_o(irq)
  );

  task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input int a, output logic [31:0] d);
    addr = AW'(a); #1; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // compare select must be 2 (active image) and vreg not 2 on entry
  task automatic set_status(input logic [3:0] p);
    wreg(2, 32'hF);
    if (p[0]) begin @(negedge clk); ufl = 1'b1; @(negedge clk); ufl = 1'b0; end
    if (p[3]) begin @(negedge clk); berr = 1'b1; @(negedge clk); berr = 1'b0; end
    if (p[1]) begin
      wreg(4, 32'h100);
      @(negedge clk); fstart = 1'b1; @(negedge clk); fstart = 1'b0;
    end
    if (p[2]) begin @(negedge clk); vreg = 2'd2; @(negedge clk); end
    @(negedge clk); vreg = 2'd0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    // R1 reset state
    idle(3);
    rreg(3, r); ck("R1 status", r, 0);
    rreg(1, r); ck("R1 enable", r, 0);
    rreg(0, r); ck("R1 select", r, 0);
    rreg(5, r); ck("R1 base", r, 0);
    ck("R1 irq", {27'd0, ivec, irq}, 0);
    rst_n = 1'b1;
    idle(1);
    rreg(3, r); ck("R1 status after release", r, 0);

    // R2 sticky latch with enable zero, bit positions
    @(negedge clk); berr = 1'b1; @(negedge clk); berr = 1'b0;
    rreg(3, r); ck("R2 bus error bit 3", r, 32'h8);
    ck("R2 masked irq stays low", {31'd0, irq}, 0);
    idle(4);
    rreg(3, r); ck("R2 sticky", r, 32'h8);

    // R4 clear semantics
    @(negedge clk); ufl = 1'b1; @(negedge clk); ufl = 1'b0;
    wreg(2, 32'h1);
    rreg(3, r); ck("R4 selective clear", r, 32'h8);
    rreg(2, r); ck("R4 clear reads zero", r, 0);
    wreg(2, 32'hF);
    rreg(3, r); ck("R4 clear all", r, 0);

    // R5 event and clear same cycle
    @(negedge clk); ufl = 1'b1; wr = 1'b1; addr = 3'd2; wdata = 32'hF;
    @(negedge clk); ufl = 1'b0; wr = 1'b0;
    rreg(3, r); ck("R5 event wins over clear", r, 32'h1);
    wreg(2, 32'hF);

    // R9 writes to read-only registers
    wreg(3, 32'hF);
    rreg(3, r); ck("R9 status write ignored", r, 0);
    wreg(5, 32'hDEAD);
    rreg(5, r); ck("R9 active base write ignored", r, 0);

    // R8 base commit
    wreg(4, 32'h1234);
    rreg(5, r); ck("R8 no commit before frame start", r, 0);
    @(negedge clk); fstart = 1'b1; @(negedge clk); fstart = 1'b0;
    rreg(5, r); ck("R8 commit value", r, 32'h1234);
    ck("R8 base port", bact, 32'h1234);
    rreg(3, r); ck("R8 base-taken bit 1", r, 32'h2);
    wreg(2, 32'hF);
    @(negedge clk); fstart = 1'b1; @(negedge clk); fstart = 1'b0;
    rreg(3, r); ck("R8 no event without pending", r, 0);
    rreg(5, r); ck("R8 base held", r, 32'h1234);

    // R10 write and frame start together
    wreg(4, 32'hAAAA);
    @(negedge clk); fstart = 1'b1; wr = 1'b1; addr = 3'd4; wdata = 32'hBBBB;
    @(negedge clk); fstart = 1'b0; wr = 1'b0;
    rreg(5, r); ck("R10 old pending committed", r, 32'hAAAA);
    @(negedge clk); fstart = 1'b1; @(negedge clk); fstart = 1'b0;
    rreg(5, r); ck("R10 new base next frame", r, 32'hBBBB);
    wreg(2, 32'hF);

    // R6 / R7 compare sweep over every select and region
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); vreg = 2'd3;
      wreg(0, 32'(s));
      rreg(0, r); ck("R6 select readback", r, 32'(s));
      idle(2);
      wreg(2, 32'hF);
      for (int rg = 0; rg < 4; rg++) begin
        @(negedge clk); vreg = 2'(rg);
        @(negedge clk);
        rreg(3, r); ck($sformatf("R6 sel %0d region %0d", s, rg), r, (rg == s) ? 32'h4 : 32'h0);
        idle(3);
        wreg(2, 32'h4);
        idle(3);
        rreg(3, r); ck("R7 no repeat inside region", r, 0);
      end
    end

    // R2 / R3 exhaustive status x mask sweep
    @(negedge clk); vreg = 2'd0;
    wreg(0, 32'd2);
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        wreg(1, 32'd0);
        set_status(4'(p));
        wreg(1, 32'(m));
        rreg(3, r); ck("R2 pattern", r, 32'(p));
        ck("R3 masked vector", {28'd0, ivec}, 32'(p & m));
        ck("R3 combined", {31'd0, irq}, ((p & m) != 0) ? 1 : 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule